// File: doc/BRIEF.md
# Loop-Cycle Coarse Counter for a Folded Delay-Line TDC

This block extends the range of a time-to-digital converter whose short delay line is closed into a ring. The start edge keeps circulating, and the block counts the completed trips from the ring's wrap pulse. A second register lags the main one by half a trip. It is loaded at the moment the edge passes the ring's midpoint. When the asynchronous stop request arrives, it is synchronized. The block then freezes the measurement and joins the trip count with the captured fine position into a single wide code. The half of the ring that the fine code points into decides which counter copy is trusted. For this reason a stop that lands next to a wrap never produces an error of a whole trip.

The block is used with a ring model and a fine decoder. `ring_wrap` is a one-cycle pulse for each completed trip. `ring_half` is a level that is high while the edge is in the upper half of the ring. `fine_code` is the binary position latched by the stop, and it is held steady while the stop request is high. The result leaves through a valid/ready output. The code is held until it is accepted, and the next measurement can start only after that acceptance. `start`, `stop_req` and the ring inputs are plain control pins and have no handshake.

Top module: `loop_coarse_counter`

## Requirements
- R1: After reset, `res_valid`, `res_sat` and `res_code` are all 0.
- R2: When `fine_code` has its most significant bit set (upper half of the ring), the result equals (number of `ring_wrap` pulses since `start`) × 2^FINE_W + `fine_code`. With the defaults this is the count times 8 plus the fine code.
- R3: When the most significant bit of `fine_code` is clear (lower half), the result counts the trip in progress as complete. It equals (number of `ring_half` rises since `start`) × 2^FINE_W + `fine_code`. This holds even when a `ring_wrap` pulse arrives on the same clock edge as the capture.
- R4: `stop_req` passes through two synchronizing flops. If the rise of `stop_req` is first sampled at clock edge E, `res_valid` is still low after edge E+1 and is high after edge E+2.
- R5: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_code` and `res_sat` stay unchanged. One edge with both high drops `res_valid` on that same edge.
- R6: A `start` pulse is ignored while a result is pending. The pending code does not change, and after acceptance a `stop_req` rise gives no result until a fresh `start` is applied.
- R7: If a wrap arrives when the count is already at 2^CNT_W−1, or if the selected count exceeds that value, `res_sat` is 1 and `res_code` is all ones. A count of exactly 2^CNT_W−1 with `res_sat` at 0 is still a legal result.
- R8: Each accepted `start` clears both counter copies and the saturation state, so every measurement counts from zero.
- R9: A `stop_req` rise while no measurement is running produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that clears the counters and begins a measurement when idle |
| ring_wrap | input | 1 | One-cycle pulse per completed trip of the ring |
| ring_half | input | 1 | High while the edge is in the upper half of the ring |
| stop_req | input | 1 | Asynchronous stop request, level |
| fine_code | input | FINE_W | Binary in-ring position latched by the stop |
| res_ready | input | 1 | Consumer accepts the result |
| res_valid | output | 1 | Result is pending |
| res_code | output | CNT_W+FINE_W | Combined coarse and fine code |
| res_sat | output | 1 | Count overflowed; code pinned to all ones |

## Verification
The embedded properties are checked on every cycle. They cover the output hold under back-pressure and the drop after acceptance, the one-step advance of the main counter per wrap, the clearing done by a start, a start being ignored while a result is pending, and the single-cycle stop edge out of the synchronizer. Only the bench scenarios can show the arithmetic of the combined code and the choice of counter copy, above all a wrap that coincides with the capture edge. They also show the exact two-edge synchronizer latency, the boundary between the largest legal code and saturation, and the absence of any result from a stop that arrives while idle.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } lcc_state_e;
endpackage

// File: rtl/lcc_stop_sync.sv
module lcc_stop_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [SYNC_N:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_N-1:0], async_in};
  end

  assign rise_pulse = chain[SYNC_N-1] & ~chain[SYNC_N];

  // R4: the synchronized edge lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/lcc_loop_counter.sv
module lcc_loop_counter #(
  parameter int CNT_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           en,
  input  logic           wrap,
  input  logic           half,
  output logic [CNT_W-1:0] cnt_main,
  output logic [CNT_W:0]   cnt_lag,
  output logic           sat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic half_q;
  logic half_rise;

  assign half_rise = half & ~half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= 1'b0;
      cnt_main <= '0;
      cnt_lag  <= '0;
      sat      <= 1'b0;
    end else begin
      half_q <= half;
      if (clr) begin
        cnt_main <= '0;
        cnt_lag  <= '0;
        sat      <= 1'b0;
      end else if (en) begin
        if (wrap) begin
          if (cnt_main == CNT_MAX) sat <= 1'b1;
          else                     cnt_main <= cnt_main + 1'b1;
        end
        if (half_rise) cnt_lag <= {1'b0, cnt_main} + 1'b1;
      end
    end
  end

  // R2: each wrap below the limit advances the main count by one
  a_r2_wrap_count: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && wrap && cnt_main != CNT_MAX) |=> cnt_main == $past(cnt_main) + 1'b1);

  // R8: a start clears both copies and the saturation state
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_main == '0 && cnt_lag == '0 && !sat));
endmodule

// File: rtl/lcc_merge.sv
module lcc_merge #(
  parameter int CNT_W  = 4,
  parameter int FINE_W = 3
) (
  input  logic [CNT_W-1:0]        cnt_main,
  input  logic [CNT_W:0]          cnt_lag,
  input  logic                    sat_in,
  input  logic [FINE_W-1:0]       fine,
  output logic [CNT_W+FINE_W-1:0] code,
  output logic                    sat_out
);
  logic [CNT_W:0] chosen;

  always_comb begin
    chosen  = fine[FINE_W-1] ? {1'b0, cnt_main} : cnt_lag;
    sat_out = sat_in | chosen[CNT_W];
    code    = sat_out ? '1 : {chosen[CNT_W-1:0], fine};
  end
endmodule

// File: rtl/loop_coarse_counter.sv
module loop_coarse_counter #(
  parameter int CNT_W  = 4,
  parameter int FINE_W = 3,
  parameter int SYNC_N = 2,
  localparam int RES_W = CNT_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ring_wrap,
  input  logic              ring_half,
  input  logic              stop_req,
  input  logic [FINE_W-1:0] fine_code,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_code,
  output logic              res_sat
);
  import lcc_pkg::*;

  lcc_state_e state;
  logic stop_edge;
  logic clr, en;
  logic [CNT_W-1:0] cnt_main;
  logic [CNT_W:0]   cnt_lag;
  logic             cnt_sat;
  logic [RES_W-1:0] merged_code;
  logic             merged_sat;

  assign clr = (state == ST_IDLE) && start;
  assign en  = (state == ST_RUN);

  lcc_stop_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(stop_req), .rise_pulse(stop_edge)
  );

  lcc_loop_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
    .wrap(ring_wrap), .half(ring_half),
    .cnt_main(cnt_main), .cnt_lag(cnt_lag), .sat(cnt_sat)
  );

  lcc_merge #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_merge (
    .cnt_main(cnt_main), .cnt_lag(cnt_lag), .sat_in(cnt_sat),
    .fine(fine_code), .code(merged_code), .sat_out(merged_sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      res_code <= '0;
      res_sat  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_RUN;
        ST_RUN: if (stop_edge) begin
          res_code <= merged_code;
          res_sat  <= merged_sat;
          state    <= ST_HOLD;
        end
        ST_HOLD: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign res_valid = (state == ST_HOLD);

  // R5: pending result is held under back-pressure
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) && $stable(res_sat)));

  // R5: acceptance drops valid
  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_valid);

  // R6: start while a result is pending does not restart counting
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && start) |=> !en);

  // R7: saturation always pins the code to all ones
  a_r7_sat_code: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_sat) |-> (res_code == {RES_W{1'b1}}));
endmodule

// File: tb/loop_coarse_counter_bench.sv
module loop_coarse_counter_bench;
  localparam int CNT_W  = 4;
  localparam int FINE_W = 3;
  localparam int RES_W  = CNT_W + FINE_W;
  localparam int NV     = 6;
  // loops, fine, wrap-on-capture flag, expected code
  localparam int TL [NV] = '{2, 3, 0, 4, 1, 7};
  localparam int TF [NV] = '{5, 1, 6, 2, 0, 4};
  localparam int TW [NV] = '{0, 0, 0, 1, 1, 0};
  localparam int TE [NV] = '{21, 25, 6, 34, 8, 60};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ring_wrap = 1'b0, ring_half = 1'b0, stop_req = 1'b0;
  logic [FINE_W-1:0] fine_code = '0;
  logic res_ready = 1'b0;
  logic res_valid;
  logic [RES_W-1:0] res_code;
  logic res_sat;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loop_coarse_counter #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_loop_coarse_counter (
    .clk(clk), .rst_n(rst_n), .start(start), .ring_wrap(ring_wrap),
    .ring_half(ring_half), .stop_req(stop_req), .fine_code(fine_code),
    .res_ready(res_ready), .res_valid(res_valid), .res_code(res_code), .res_sat(res_sat)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic one_loop();
    @(negedge clk) ring_half = 1'b1;
    @(negedge clk);
    @(negedge clk) begin ring_half = 1'b0; ring_wrap = 1'b1; end
    @(negedge clk) ring_wrap = 1'b0;
  endtask

  // run a measurement; leaves the result pending
  task automatic measure(input int loops, input int fine, input bit coinc);
    int full;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    full = coinc ? loops - 1 : loops;
    for (int i = 0; i < full; i++) one_loop();
    if (coinc || fine >= (1 << (FINE_W - 1))) begin
      @(negedge clk) ring_half = 1'b1;
      @(negedge clk);
    end
    @(negedge clk) begin
      stop_req = 1'b1;
      fine_code = FINE_W'(fine);
      if (coinc) ring_half = 1'b0;
    end
    @(negedge clk);
    @(negedge clk) begin
      chk("R4 valid low one edge after sync", int'(res_valid), 0);
      if (coinc) ring_wrap = 1'b1;
    end
    @(negedge clk) begin
      ring_wrap = 1'b0;
      ring_half = 1'b0;
      chk("R4 valid two edges after sync", int'(res_valid), 1);
    end
  endtask

  task automatic accept(input int exp_code);
    @(negedge clk) chk("R5 held code", int'(res_code), exp_code);
    @(negedge clk) chk("R5 held valid", int'(res_valid), 1);
    res_ready = 1'b1;
    @(negedge clk) begin
      res_ready = 1'b0;
      chk("R5 dropped after accept", int'(res_valid), 0);
      stop_req = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid at reset", int'(res_valid), 0);
    chk("R1 code at reset", int'(res_code), 0);
    chk("R1 sat at reset", int'(res_sat), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: stop while idle
    stop_req = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 no result while idle", int'(res_valid), 0);
    stop_req = 1'b0;
    repeat (3) @(negedge clk);

    // table walk: R2 (upper half), R3 (lower half, incl. wrap on capture), R8 fresh count
    for (int v = 0; v < NV; v++) begin
      measure(TL[v], TF[v], TW[v] != 0);
      chk(TF[v] >= 4 ? "R2 combined code" : "R3 lower-half code", int'(res_code), TE[v]);
      chk("R8 no sat in fresh count", int'(res_sat), 0);
      accept(TE[v]);
    end

    // R6: start ignored while pending
    measure(1, 6, 1'b0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    one_loop();
    chk("R6 code unchanged by start", int'(res_code), 14);
    accept(14);
    stop_req = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 no restart after ignored start", int'(res_valid), 0);
    stop_req = 1'b0;
    repeat (3) @(negedge clk);

    // R7: largest legal code, then overflow
    measure(15, 7, 1'b0);
    chk("R7 max legal code", int'(res_code), 127);
    chk("R7 max legal no sat", int'(res_sat), 0);
    accept(127);
    measure(16, 5, 1'b0);
    chk("R7 saturated code", int'(res_code), 127);
    chk("R7 saturation flag", int'(res_sat), 1);
    accept(127);
    measure(16, 2, 1'b0);
    chk("R7 lower-half overflow flag", int'(res_sat), 1);
    accept(127);

    // R8: after saturation a new start counts from zero
    measure(0, 3, 1'b0);
    chk("R8 cleared after saturation", int'(res_code), 3);
    chk("R8 sat cleared", int'(res_sat), 0);
    accept(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule